// File: doc/BRIEF.md
# Periodic Comparator Event Timer

This block is a register-mapped event timer. A free-running main counter advances by one on every clock while the global run bit is set. A single comparator channel watches that counter. When the two match, the channel can raise a level interrupt. In one-shot mode the comparator then stays where it is. In periodic mode it moves forward by a hidden reload amount, so the next event is scheduled without touching the counter.

Software reaches the block through a plain register bus. The bus has a select, a write strobe, a 3-bit address, write data and combinational read data. The bus is control traffic, so it carries no valid/ready handshake: every selected cycle completes at once. Write data is taken at the rising edge. Read data follows the address within the same cycle.

The hidden reload register keeps the last value written to the comparator. A self-clearing set-value bit lets software program both the first deadline and the period while the counter runs. The first comparator write after the bit is set loads the deadline, and the second write loads only the period. A legacy-routing bit moves the channel's interrupt from its own output to the legacy system-timer output.

Top module: `event_timer`

Register map (address: contents):
- 0: capability, read-only. Bit 0 reads 1 when legacy routing is supported. Bits [15:8] give the counter width.
- 1: global configuration. Bit 0 is run, bit 1 is legacy routing.
- 2: status. Bit 0 is the latched event. Writing 1 clears it.
- 3: main counter.
- 4: channel configuration. Bit 0 is interrupt enable, bit 1 is periodic, bit 2 is set-value and bit 3 is 32-bit mode.
- 5: comparator.

## Requirements
- R1: The capability word at address 0 reads bit 0 = 1 (legacy routing supported) and bits [15:8] = counter width. Writes to address 0 change nothing.
- R2: While global bit 0 (run) is 0, the counter holds its value. While it is 1, the counter gains 1 at every rising edge.
- R3: A write to address 3 loads the counter only while run is 0. While run is 1 the write is ignored and counting continues.
- R4: While run is 1, a match between the comparator and the counter sets status bit 0 at the next edge, but only if interrupt enable (channel bit 0) is 1. The status bit drives a level interrupt. Writing 1 to status bit 0 clears it, and writing 0 has no effect.
- R5: In one-shot mode (channel bit 1 = 0), a match leaves the comparator unchanged and produces one event only.
- R6: In periodic mode (channel bit 1 = 1), a match adds the hidden reload value to the comparator.
- R7: A comparator write while set-value is 0 loads both the comparator and the hidden reload register.
- R8: After set-value (channel bit 2) is written as 1, the next comparator write loads both values. The write after that loads only the reload register and returns bit 2 to 0. Bit 2 reads 1 until that second write.
- R9: In 32-bit mode (channel bit 3 = 1), the match compares only the low 32 bits. The periodic addition wraps modulo 2^32, and the upper comparator bits become 0.
- R10: When global bit 1 (legacy routing) is 1, the event drives `irq_legacy` and holds `irq_chan` low. When the bit is 0, the event drives `irq_chan` and holds `irq_legacy` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | CNT_W | Write data |
| bus_rdata | output | CNT_W | Read data (combinational) |
| irq_chan | output | 1 | Channel interrupt, normal routing |
| irq_legacy | output | 1 | Legacy system-timer interrupt |

## Verification
Several rules are checked by assertions on every cycle:
- the counter holds while stopped, steps while running, and loads only while stopped;
- a one-shot match leaves the comparator unchanged, and a full-width periodic match adds the reload value;
- the set-value bit clears after its second comparator write;
- an enabled match latches status;
- at most one interrupt line is ever high, and it is the one that legacy routing selects.

Other behaviour shows only in the bench's scenarios:
- the exact edge on which the first interrupt rises;
- that the reload register really holds the second write of a set-value pair;
- wraparound in 32-bit mode with nonzero upper counter bits;
- the comparator values reached after long random periodic runs.

// File: rtl/etmr_pkg.sv
package etmr_pkg;
  typedef enum logic [2:0] {
    A_CAP   = 3'd0,
    A_GCFG  = 3'd1,
    A_STAT  = 3'd2,
    A_COUNT = 3'd3,
    A_CHCFG = 3'd4,
    A_CMP   = 3'd5
  } reg_addr_e;

  localparam int GC_RUN  = 0;
  localparam int GC_LEG  = 1;
  localparam int CH_IEN  = 0;
  localparam int CH_PER  = 1;
  localparam int CH_SETV = 2;
  localparam int CH_N32  = 3;
  localparam int CAP_LEG = 0;
endpackage

// File: rtl/etmr_counter.sv
module etmr_counter #(
  parameter int W = 48
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run_i,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] cnt_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (run_i)   cnt_q <= cnt_q + 1'b1;
    else if (wr_i)    cnt_q <= wdata_i;
  end

  assign cnt_o = cnt_q;

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_i && !wr_i) |=> cnt_q == $past(cnt_q));
  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    run_i |=> cnt_q == $past(cnt_q) + 1'b1);
  p_load_stopped_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_i && wr_i) |=> cnt_q == $past(wdata_i));
endmodule

// File: rtl/etmr_channel.sv
module etmr_channel
  import etmr_pkg::*;
#(
  parameter int W  = 48,
  parameter int NW = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run_i,
  input  logic [W-1:0] cnt_i,
  input  logic         cfg_wr_i,
  input  logic         cmp_wr_i,
  input  logic         stat_clr_i,
  input  logic [W-1:0] wdata_i,
  output logic [3:0]   cfg_o,
  output logic [W-1:0] cmp_o,
  output logic         status_o
);
  localparam logic [W-1:0] LOW_MASK = {{(W-NW){1'b0}}, {NW{1'b1}}};

  logic         ien_q, per_q, n32_q, arm_q, second_q, status_q;
  logic [W-1:0] cmp_q, reload_q, cmp_mask, sum, next_cmp;
  logic         hit;

  assign cmp_mask = n32_q ? LOW_MASK : '1;
  assign hit      = run_i && (((cnt_i ^ cmp_q) & cmp_mask) == '0);
  assign sum      = cmp_q + reload_q;
  assign next_cmp = sum & cmp_mask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien_q    <= 1'b0;
      per_q    <= 1'b0;
      n32_q    <= 1'b0;
      arm_q    <= 1'b0;
      second_q <= 1'b0;
      cmp_q    <= '1;
      reload_q <= '0;
      status_q <= 1'b0;
    end else begin
      if (cfg_wr_i) begin
        ien_q    <= wdata_i[CH_IEN];
        per_q    <= wdata_i[CH_PER];
        n32_q    <= wdata_i[CH_N32];
        arm_q    <= wdata_i[CH_SETV];
        second_q <= 1'b0;
      end
      if (cmp_wr_i) begin
        if (arm_q && second_q) begin
          reload_q <= wdata_i;
          arm_q    <= 1'b0;
          second_q <= 1'b0;
        end else begin
          cmp_q    <= wdata_i;
          reload_q <= wdata_i;
          if (arm_q) second_q <= 1'b1;
        end
      end else if (hit && per_q) begin
        cmp_q <= next_cmp;
      end
      if (hit && ien_q)    status_q <= 1'b1;
      else if (stat_clr_i) status_q <= 1'b0;
    end
  end

  assign cfg_o    = {n32_q, arm_q, per_q, ien_q};
  assign cmp_o    = cmp_q;
  assign status_o = status_q;

  p_status_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && ien_q) |=> status_q);
  p_oneshot_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !per_q && !cmp_wr_i) |=> cmp_q == $past(cmp_q));
  p_reload_add_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && per_q && !n32_q && !cmp_wr_i && !cfg_wr_i) |=>
      cmp_q == $past(cmp_q) + $past(reload_q));
  p_setv_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (arm_q && second_q && cmp_wr_i && !cfg_wr_i) |=> !arm_q);
endmodule

// File: rtl/etmr_irq_route.sv
module etmr_irq_route #(
  parameter bit LEG_CAP = 1'b1
) (
  input  logic status_i,
  input  logic legacy_i,
  output logic irq_chan_o,
  output logic irq_legacy_o
);
  logic steer;

  generate
    if (LEG_CAP) begin : g_leg
      assign steer = legacy_i;
    end else begin : g_noleg
      assign steer = 1'b0;
    end
  endgenerate

  assign irq_chan_o   = status_i && !steer;
  assign irq_legacy_o = status_i && steer;
endmodule

// File: rtl/event_timer.sv
module event_timer
  import etmr_pkg::*;
#(
  parameter int CNT_W   = 48,
  parameter int NARROW  = 32,
  parameter bit LEG_CAP = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_sel,
  input  logic             bus_we,
  input  logic [2:0]       bus_addr,
  input  logic [CNT_W-1:0] bus_wdata,
  output logic [CNT_W-1:0] bus_rdata,
  output logic             irq_chan,
  output logic             irq_legacy
);
  localparam logic [7:0] WIDTH_CODE = 8'(CNT_W);

  logic             wr_en;
  logic             run_q, legacy_q;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cmp;
  logic [3:0]       ch_cfg;
  logic             status;
  reg_addr_e        addr;

  assign addr  = reg_addr_e'(bus_addr);
  assign wr_en = bus_sel && bus_we;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q    <= 1'b0;
      legacy_q <= 1'b0;
    end else if (wr_en && addr == A_GCFG) begin
      run_q    <= bus_wdata[GC_RUN];
      legacy_q <= LEG_CAP && bus_wdata[GC_LEG];
    end
  end

  etmr_counter #(.W(CNT_W)) u_counter (
    .clk     (clk),
    .rst_n   (rst_n),
    .run_i   (run_q),
    .wr_i    (wr_en && addr == A_COUNT),
    .wdata_i (bus_wdata),
    .cnt_o   (cnt)
  );

  etmr_channel #(.W(CNT_W), .NW(NARROW)) u_channel (
    .clk        (clk),
    .rst_n      (rst_n),
    .run_i      (run_q),
    .cnt_i      (cnt),
    .cfg_wr_i   (wr_en && addr == A_CHCFG),
    .cmp_wr_i   (wr_en && addr == A_CMP),
    .stat_clr_i (wr_en && addr == A_STAT && bus_wdata[0]),
    .wdata_i    (bus_wdata),
    .cfg_o      (ch_cfg),
    .cmp_o      (cmp),
    .status_o   (status)
  );

  etmr_irq_route #(.LEG_CAP(LEG_CAP)) u_route (
    .status_i     (status),
    .legacy_i     (legacy_q),
    .irq_chan_o   (irq_chan),
    .irq_legacy_o (irq_legacy)
  );

  always_comb begin
    bus_rdata = '0;
    unique case (addr)
      A_CAP:   begin
                 bus_rdata[CAP_LEG] = LEG_CAP;
                 bus_rdata[15:8]    = WIDTH_CODE;
               end
      A_GCFG:  begin
                 bus_rdata[GC_RUN] = run_q;
                 bus_rdata[GC_LEG] = legacy_q;
               end
      A_STAT:  bus_rdata[0]   = status;
      A_COUNT: bus_rdata      = cnt;
      A_CHCFG: bus_rdata[3:0] = ch_cfg;
      A_CMP:   bus_rdata      = cmp;
      default: bus_rdata      = '0;
    endcase
  end

  p_one_line_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq_chan && irq_legacy));
  p_legacy_steer_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (status && legacy_q) |-> (irq_legacy && !irq_chan));
  p_normal_steer_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (status && !legacy_q) |-> (irq_chan && !irq_legacy));
endmodule

// File: tb/test_event_timer.sv
module test_event_timer;
  localparam int W = 48;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         bus_sel = 1'b0, bus_we = 1'b0;
  logic [2:0]   bus_addr = '0;
  logic [W-1:0] bus_wdata = '0;
  logic [W-1:0] bus_rdata;
  logic         irq_chan, irq_legacy;

  int n_chk = 0, n_fail = 0;
  logic [W-1:0] r;

  always #4 clk = ~clk;

  event_timer i_event_timer (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_chan(irq_chan), .irq_legacy(irq_legacy)
  );

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [W-1:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  // Comparator after counter values 0..last are seen while running.
  function automatic logic [W-1:0] exp_periodic(input logic [W-1:0] start,
      input logic [W-1:0] rel, input int last);
    logic [W-1:0] c = start;
    for (int v = 0; v <= last; v++) if (W'(v) == c) c = c + rel;
    return c;
  endfunction

  task automatic report;
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(8 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    report();
  end

  initial begin
    int seed, k, first;
    seed = $urandom(32'h5eed);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // Reset state
    rd(3'd3, r); chk("reset count", r, '0);
    rd(3'd1, r); chk("reset gcfg", r, '0);
    rd(3'd4, r); chk("reset chcfg", r, '0);
    chk("reset irqs", {46'd0, irq_chan, irq_legacy}, '0);

    // R1 capability read-only
    rd(3'd0, r); chk("R1 cap", r, 48'h3001);
    wr(3'd0, '0);
    rd(3'd0, r); chk("R1 cap after write", r, 48'h3001);

    // R2 hold while stopped, step while running
    wr(3'd3, 48'd100);
    repeat (5) @(posedge clk);
    rd(3'd3, r); chk("R2 hold", r, 48'd100);
    k = 3 + $urandom % 20;
    wr(3'd1, 48'd1);
    repeat (k) @(posedge clk);
    wr(3'd1, 48'd0);
    rd(3'd3, r); chk("R2 step", r, W'(100 + k + 1));

    // R3 write ignored while running
    wr(3'd3, 48'd100);
    wr(3'd1, 48'd1);
    repeat (k) @(posedge clk);
    wr(3'd3, 48'd5);
    wr(3'd1, 48'd0);
    rd(3'd3, r); chk("R3 ignored", r, W'(100 + k + 2));

    // R4/R5 one-shot timing, comparator unchanged, single event
    wr(3'd3, '0);
    wr(3'd4, 48'h1);
    k = 10 + $urandom % 30;
    wr(3'd5, W'(k));
    wr(3'd1, 48'd1);
    first = 0;
    for (int j = 1; j < 200 && first == 0; j++) begin
      @(posedge clk); #1;
      if (irq_chan) first = j;
    end
    chk("R4 first irq edge", W'(first), W'(k + 1));
    chk("R10 legacy low", {47'd0, irq_legacy}, '0);
    rd(3'd5, r); chk("R5 cmp kept", r, W'(k));
    wr(3'd2, '0);
    rd(3'd2, r); chk("R4 write 0 keeps", r, 48'd1);
    wr(3'd2, 48'd1);
    repeat (20) @(posedge clk);
    rd(3'd2, r); chk("R5 single event", r, '0);
    chk("R4 irq released", {47'd0, irq_chan}, '0);
    wr(3'd1, '0);

    // R6/R7 random periodic runs, alternating interrupt enable
    for (int i = 0; i < 8; i++) begin
      logic [W-1:0] p;
      p = W'(1 + $urandom % 9);
      k = 10 + $urandom % 60;
      wr(3'd3, '0);
      wr(3'd4, W'(2 | (i % 2)));
      wr(3'd5, p);
      wr(3'd1, 48'd1);
      repeat (k) @(posedge clk);
      wr(3'd1, '0);
      rd(3'd5, r); chk("R6 R7 periodic cmp", r, exp_periodic(p, p, k));
      rd(3'd2, r); chk("R4 status by enable", r, W'(i % 2));
      wr(3'd2, 48'd1);
    end

    // R8 set-value sequence
    wr(3'd3, '0);
    wr(3'd4, 48'h7);
    rd(3'd4, r); chk("R8 armed", W'(r[2]), 48'd1);
    wr(3'd5, 48'd20);
    rd(3'd4, r); chk("R8 still armed", W'(r[2]), 48'd1);
    wr(3'd5, 48'd7);
    rd(3'd4, r); chk("R8 self-cleared", W'(r[2]), '0);
    rd(3'd5, r); chk("R8 cmp kept first", r, 48'd20);
    wr(3'd1, 48'd1);
    repeat (30) @(posedge clk);
    wr(3'd1, '0);
    rd(3'd5, r); chk("R8 reload from second", r, exp_periodic(48'd20, 48'd7, 30));

    // R10 legacy routing
    wr(3'd1, 48'd2);
    chk("R10 legacy on", {46'd0, irq_chan, irq_legacy}, 48'd1);
    wr(3'd1, '0);
    chk("R10 legacy off", {46'd0, irq_chan, irq_legacy}, 48'd2);
    wr(3'd2, 48'd1);

    // R9 32-bit mode wrap
    wr(3'd3, 48'h5_FFFF_FFF0);
    wr(3'd4, 48'hF);
    wr(3'd5, 48'hFFFF_FFF8);
    wr(3'd5, 48'h10);
    wr(3'd1, 48'd1);
    repeat (20) @(posedge clk);
    wr(3'd1, '0);
    rd(3'd5, r); chk("R9 wrapped cmp", r, 48'd8);
    rd(3'd2, r); chk("R9 narrow match", r, 48'd1);
    rd(3'd3, r); chk("R9 count", r, 48'h6_0000_0005);

    report();
  end
endmodule